// File: doc/BRIEF.md
# Acceleration Read Request Responder

This block sits behind the receiver of a two-wire sensor bus. Each decoded request frame comes in as one word on a valid/ready stream: an 8-bit filler byte, a 4-bit node address, a 4-bit opcode and a received check code. The block checks the frame against its own CRC and filters it by opcode and node address. For each request it accepts, it builds one reply frame from the current 10-bit acceleration sample and the status flags.

The reply layout depends on a format select and a configured reply length. In the compact format the reply is 8 to 15 data bits wide. At 8 or 9 bits the sample loses its low bits, and a result of zero is replaced by a minimum code. From 10 bits upward the full sample is sent, followed by the status bits. The wide format is always 16 bits and repeats the node address. A CRC over the reply data goes out with every reply, and the total bit count is reported with it.

Back-pressure works as follows. A reply is held on the output, unchanged, until `rsp_ready` is high at a clock edge. While a reply waits, `req_ready` is low, so no request is taken. When `rsp_ready` is high, a new request can be accepted in the same cycle that the pending reply leaves.

Top module: `accrd_responder`

## Requirements
- R1: A request is answered only when its opcode field equals 4'b0010. Any other opcode produces no reply.
- R2: A request is answered only when its address equals `dev_addr` and is not 4'b0000. A request to address 4'b0000 produces no reply, even when `dev_addr` is 4'b0000.
- R3: The filler byte only enters the request CRC. Requests that differ only in that byte, each with a correct CRC, give identical replies.
- R4: The request CRC is the CRC_W-bit code over the 16 bits {filler[7:0], address[3:0], opcode[3:0]}, fed MSB first from seed CRC_SEED with polynomial CRC_POLY. In each step the feedback is the top CRC bit XOR the input bit, the CRC shifts left by one, and POLY is XORed in when the feedback is 1. A request whose `req_crc` differs from this code produces no reply.
- R5: In compact format with a reply length of 8 the data is accel[9:2]. With a length of 9 the data is accel[9:1]. The data is right-aligned in `rsp_data`, and the bits above it are 0.
- R6: When the truncated value in R5 is zero, the data is MIN_CODE (default 1).
- R7: In compact format with a length L from 10 to 15, bits 9:0 carry accel[9:0]. Above them: bit 10 is err_flag, bit 11 is 0, bit 12 is selftest, bit 13 is attr[0] and bit 14 is attr[1]. Bits at position L and above are 0.
- R8: In wide format the data is 16 bits: dev_addr in bits 15:12, 0 in bit 11, err_flag in bit 10 and accel[9:0] in bits 9:0.
- R9: `rsp_crc` is the R4 CRC taken over the L reply data bits, from bit L-1 down to bit 0. `rsp_bits` equals L + CRC_W.
- R10: A reply appears on `rsp_valid` in the cycle after the accepting edge. With `rsp_ready` held high it stays valid for exactly one cycle.
- R11: While `rsp_valid` is high and `rsp_ready` is low, the reply stays unchanged and `req_ready` is low.
- R12: In compact format, a configured length below 8 is treated as 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request word valid |
| req_ready | output | 1 | Block can take a request |
| req_fill | input | 8 | Filler byte of the request |
| req_addr | input | 4 | Request node address |
| req_op | input | 4 | Request opcode |
| req_crc | input | CRC_W | Received request check code |
| fmt_wide | input | 1 | 1 selects the 16-bit wide format |
| len_cfg | input | 4 | Compact-format reply length |
| dev_addr | input | 4 | Programmed node address |
| accel | input | 10 | Acceleration sample |
| err_flag | input | 1 | Internal error flag |
| selftest | input | 1 | Self-test active flag |
| attr | input | 2 | Attribute bits |
| rsp_valid | output | 1 | Reply valid |
| rsp_ready | input | 1 | Downstream can take the reply |
| rsp_data | output | 16 | Reply data, right-aligned |
| rsp_crc | output | CRC_W | Reply check code |
| rsp_bits | output | 5 | Data bits plus CRC bits |

## Verification
Two of the block's functions can fall in the same cycle. One is a pending reply leaving under back-pressure; the other is a new request being accepted and its reply loaded. The bench provokes this by holding a reply with `rsp_ready` low while a second request waits on the input, then raising `rsp_ready`. The handover is judged correct when the first reply held stable throughout the stall, the second request went in on the same edge that released the first reply, and the next cycle shows the second reply with its own data and CRC.

// File: rtl/accrd_pkg.sv
package accrd_pkg;
  localparam int AD_W      = 10;
  localparam int RSP_W     = 16;
  localparam int LEN_W     = 5;
  localparam int MIN_SHORT = 8;
  localparam int REQ_W     = 16;
  localparam logic [3:0] OP_ACC_READ = 4'b0010;
  localparam logic [3:0] ADDR_BCAST  = 4'b0000;

  typedef struct packed {
    logic       err;
    logic       st;
    logic [1:0] attr;
  } status_t;
endpackage

// File: rtl/acc_crc_lfsr.sv
module acc_crc_lfsr #(
  parameter int W = 4,
  parameter logic [W-1:0] POLY = 'h3,
  parameter logic [W-1:0] SEED = '1,
  parameter int N = 16,
  localparam int LW = $clog2(N + 1)
) (
  input  logic [N-1:0]  bits_i,
  input  logic [LW-1:0] len_i,
  output logic [W-1:0]  crc_o
);
  logic fb;
  always_comb begin
    crc_o = SEED;
    fb    = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (i < int'(len_i)) begin
        fb    = crc_o[W-1] ^ bits_i[i];
        crc_o = crc_o << 1;
        if (fb) crc_o = crc_o ^ POLY;
      end
    end
  end
endmodule

// File: rtl/acc_req_decode.sv
module acc_req_decode
  import accrd_pkg::*;
#(
  parameter int CRC_W = 4,
  parameter logic [CRC_W-1:0] CRC_POLY = 'h3,
  parameter logic [CRC_W-1:0] CRC_SEED = '1
) (
  input  logic [7:0]       fill_i,
  input  logic [3:0]       addr_i,
  input  logic [3:0]       op_i,
  input  logic [CRC_W-1:0] crc_i,
  input  logic [3:0]       dev_addr_i,
  output logic             hit_o
);
  localparam int LW = $clog2(REQ_W + 1);
  logic [CRC_W-1:0] calc;

  acc_crc_lfsr #(.W(CRC_W), .POLY(CRC_POLY), .SEED(CRC_SEED), .N(REQ_W)) u_chk (
    .bits_i ({fill_i, addr_i, op_i}),
    .len_i  (LW'(REQ_W)),
    .crc_o  (calc)
  );

  always_comb begin
    hit_o = (calc == crc_i) && (op_i == OP_ACC_READ) &&
            (addr_i == dev_addr_i) && (addr_i != ADDR_BCAST);
  end
endmodule

// File: rtl/acc_rsp_format.sv
module acc_rsp_format
  import accrd_pkg::*;
#(
  parameter logic [AD_W-1:0] MIN_CODE = 'd1
) (
  input  logic [AD_W-1:0]  sample_i,
  input  status_t          stat_i,
  input  logic [3:0]       addr_i,
  input  logic             wide_i,
  input  logic [3:0]       len_cfg_i,
  output logic [RSP_W-1:0] word_o,
  output logic [LEN_W-1:0] len_o
);
  localparam int N_TRUNC = AD_W - MIN_SHORT;

  logic [N_TRUNC:0][AD_W-1:0] trunc;
  logic [RSP_W-2:0]           full;

  assign trunc[0] = sample_i;
  for (genvar k = 1; k <= N_TRUNC; k++) begin : g_trunc
    logic [AD_W-1:0] shifted;
    assign shifted  = sample_i >> k;
    assign trunc[k] = (shifted == '0) ? MIN_CODE : shifted;
  end

  assign full = {stat_i.attr[1], stat_i.attr[0], stat_i.st, 1'b0, stat_i.err, sample_i};

  always_comb begin
    if (wide_i)
      len_o = LEN_W'(RSP_W);
    else if (int'(len_cfg_i) < MIN_SHORT)
      len_o = LEN_W'(MIN_SHORT);
    else
      len_o = LEN_W'(len_cfg_i);

    if (wide_i)
      word_o = {addr_i, 1'b0, stat_i.err, sample_i};
    else if (int'(len_o) < AD_W)
      word_o = RSP_W'(trunc[AD_W - int'(len_o)]);
    else
      word_o = RSP_W'(full) & ((RSP_W'(1) << len_o) - RSP_W'(1));
  end
endmodule

// File: rtl/accrd_responder.sv
module accrd_responder
  import accrd_pkg::*;
#(
  parameter int CRC_W = 4,
  parameter logic [CRC_W-1:0] CRC_POLY = 'h3,
  parameter logic [CRC_W-1:0] CRC_SEED = '1,
  parameter logic [9:0] MIN_CODE = 10'd1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [7:0]       req_fill,
  input  logic [3:0]       req_addr,
  input  logic [3:0]       req_op,
  input  logic [CRC_W-1:0] req_crc,
  input  logic             fmt_wide,
  input  logic [3:0]       len_cfg,
  input  logic [3:0]       dev_addr,
  input  logic [9:0]       accel,
  input  logic             err_flag,
  input  logic             selftest,
  input  logic [1:0]       attr,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic [15:0]      rsp_data,
  output logic [CRC_W-1:0] rsp_crc,
  output logic [4:0]       rsp_bits
);
  logic             hit;
  logic             accept;
  logic [RSP_W-1:0] word;
  logic [LEN_W-1:0] len;
  logic [CRC_W-1:0] word_crc;
  status_t          stat;

  assign stat = '{err: err_flag, st: selftest, attr: attr};

  acc_req_decode #(.CRC_W(CRC_W), .CRC_POLY(CRC_POLY), .CRC_SEED(CRC_SEED)) u_dec (
    .fill_i     (req_fill),
    .addr_i     (req_addr),
    .op_i       (req_op),
    .crc_i      (req_crc),
    .dev_addr_i (dev_addr),
    .hit_o      (hit)
  );

  acc_rsp_format #(.MIN_CODE(MIN_CODE)) u_fmt (
    .sample_i  (accel),
    .stat_i    (stat),
    .addr_i    (dev_addr),
    .wide_i    (fmt_wide),
    .len_cfg_i (len_cfg),
    .word_o    (word),
    .len_o     (len)
  );

  acc_crc_lfsr #(.W(CRC_W), .POLY(CRC_POLY), .SEED(CRC_SEED), .N(RSP_W)) u_rcrc (
    .bits_i (word),
    .len_i  (len),
    .crc_o  (word_crc)
  );

  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready && hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
      rsp_crc   <= '0;
      rsp_bits  <= '0;
    end else begin
      if (req_ready) rsp_valid <= accept;
      if (accept) begin
        rsp_data <= word;
        rsp_crc  <= word_crc;
        rsp_bits <= len + LEN_W'(CRC_W);
      end
    end
  end
endmodule

// File: rtl/accrd_checker.sv
module accrd_checker #(
  parameter int CRC_W = 4
) (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic [3:0]  req_addr,
  input logic [3:0]  req_op,
  input logic        rsp_valid,
  input logic        rsp_ready,
  input logic [15:0] rsp_data,
  input logic [4:0]  rsp_bits
);
  // R1
  op_filter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_op != 4'b0010) |=> !rsp_valid);

  // R2
  bcast_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_addr == 4'b0000) |=> !rsp_valid);

  // R11
  hold_reply_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data) && $stable(rsp_bits)));

  // R11
  stall_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready);

  // R9
  bit_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (int'(rsp_bits) >= 8 + CRC_W && int'(rsp_bits) <= 16 + CRC_W));

  // R7
  upper_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ((32'(rsp_data) >> (int'(rsp_bits) - CRC_W)) == 32'd0));

  // R8
  gap_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && int'(rsp_bits) >= 12 + CRC_W) |-> !rsp_data[11]);
endmodule

bind accrd_responder accrd_checker #(.CRC_W(CRC_W)) u_accrd_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_addr  (req_addr),
  .req_op    (req_op),
  .rsp_valid (rsp_valid),
  .rsp_ready (rsp_ready),
  .rsp_data  (rsp_data),
  .rsp_bits  (rsp_bits)
);

// File: tb/test_accrd_responder.sv
module test_accrd_responder;
  localparam int CRC_W = 4;
  localparam logic [CRC_W-1:0] POLY = 4'h3;
  localparam logic [CRC_W-1:0] SEED = 4'hF;
  localparam int MINC = 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [7:0] req_fill = '0;
  logic [3:0] req_addr = '0;
  logic [3:0] req_op = '0;
  logic [CRC_W-1:0] req_crc = '0;
  logic fmt_wide = 1'b0;
  logic [3:0] len_cfg = 4'd8;
  logic [3:0] dev_addr = 4'd5;
  logic [9:0] accel = '0;
  logic err_flag = 1'b0;
  logic selftest = 1'b0;
  logic [1:0] attr = '0;
  logic rsp_valid;
  logic rsp_ready = 1'b1;
  logic [15:0] rsp_data;
  logic [CRC_W-1:0] rsp_crc;
  logic [4:0] rsp_bits;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  logic got_v, after_v;
  logic [15:0] got_d;
  logic [CRC_W-1:0] got_c;
  logic [4:0] got_b;

  always #5 clk = ~clk;

  accrd_responder #(.CRC_W(CRC_W), .CRC_POLY(POLY), .CRC_SEED(SEED)) i_accrd_responder (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_fill(req_fill), .req_addr(req_addr), .req_op(req_op), .req_crc(req_crc),
    .fmt_wide(fmt_wide), .len_cfg(len_cfg), .dev_addr(dev_addr), .accel(accel),
    .err_flag(err_flag), .selftest(selftest), .attr(attr), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_data(rsp_data), .rsp_crc(rsp_crc), .rsp_bits(rsp_bits)
  );

  function automatic logic [CRC_W-1:0] crc_ref(input logic [15:0] v, input int n);
    logic [CRC_W-1:0] c = SEED;
    for (int i = n - 1; i >= 0; i--) begin
      logic f = c[CRC_W-1] ^ v[i];
      c = c << 1;
      if (f) c = c ^ POLY;
    end
    return c;
  endfunction

  function automatic int eff_len(input logic wide, input int cfg);
    if (wide) return 16;
    return (cfg < 8) ? 8 : cfg;
  endfunction

  function automatic logic [15:0] exp_word(input logic wide, input int L, input int s,
                                           input logic e, input logic st, input logic [1:0] a);
    int t;
    if (wide) return {dev_addr, 1'b0, e, 10'(s)};
    if (L < 10) begin
      t = s >> (10 - L);
      if (t == 0) t = MINC;
      return 16'(t);
    end
    t = s | (int'(e) << 10) | (int'(st) << 12) | (int'(a[0]) << 13) | (int'(a[1]) << 14);
    return 16'(t & ((1 << L) - 1));
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [3:0] op, input logic [3:0] a, input logic [7:0] f,
                      input logic [CRC_W-1:0] flip);
    @(negedge clk);
    req_op = op; req_addr = a; req_fill = f;
    req_crc = crc_ref({f, a, op}, 16) ^ flip;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    got_v = rsp_valid; got_d = rsp_data; got_c = rsp_crc; got_b = rsp_bits;
    @(negedge clk);
    after_v = rsp_valid;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  task automatic sweep_one(input logic wide, input int cfg, input int s);
    int L;
    logic [15:0] w;
    string tag;
    L = eff_len(wide, cfg);
    fmt_wide = wide; len_cfg = 4'(cfg); accel = 10'(s);
    err_flag = s[0] ^ s[4]; selftest = s[1] ^ s[5]; attr = 2'(s >> 2) ^ 2'(s >> 6);
    w = exp_word(wide, L, s, err_flag, selftest, attr);
    send(4'b0010, dev_addr, 8'(s), '0);
    if (wide) tag = "R8";
    else if (cfg < 8) tag = "R12";
    else if (L >= 10) tag = "R7";
    else if ((s >> (10 - L)) == 0) tag = "R6";
    else tag = "R5";
    check(got_v && got_d == w, tag, int'(got_d), int'(w));
    check(got_c == crc_ref(w, L) && int'(got_b) == L + CRC_W, "R9",
          int'({got_b, got_c}), int'({5'(L + CRC_W), crc_ref(w, L)}));
    check(!after_v, "R10", int'(after_v), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [15:0] ref_d;
    repeat (3) @(negedge clk);
    check(!rsp_valid && req_ready, "R10 reset", int'({rsp_valid, req_ready}), 1);
    rst_n = 1'b1;

    for (int cfg = 8; cfg <= 15; cfg++)
      for (int s = 0; s < 1024; s++) sweep_one(1'b0, cfg, s);
    for (int s = 0; s < 1024; s++) sweep_one(1'b1, 8, s);
    for (int cfg = 0; cfg < 8; cfg++)
      for (int s = 0; s < 1024; s += 97) sweep_one(1'b0, cfg, s);

    // R1: every other opcode ignored
    fmt_wide = 1'b0; len_cfg = 4'd12; accel = 10'h155;
    for (int op = 0; op < 16; op++) begin
      send(4'(op), dev_addr, 8'h3C, '0);
      check(got_v == (op == 2), "R1", int'(got_v), int'(op == 2));
    end
    // R2: address filter and broadcast address
    for (int a = 0; a < 16; a++) begin
      send(4'b0010, 4'(a), 8'h11, '0);
      check(got_v == (a == 5), "R2", int'(got_v), int'(a == 5));
    end
    dev_addr = 4'd0;
    send(4'b0010, 4'd0, 8'h11, '0);
    check(!got_v, "R2 bcast", int'(got_v), 0);
    dev_addr = 4'd5;
    // R4: any corrupted CRC bit drops the request
    for (int b = 0; b < CRC_W; b++) begin
      send(4'b0010, dev_addr, 8'hA5, CRC_W'(1) << b);
      check(!got_v, "R4", int'(got_v), 0);
    end
    // R3: filler byte has no effect on the reply
    accel = 10'h2E7; err_flag = 1'b1; selftest = 1'b0; attr = 2'b10;
    ref_d = exp_word(1'b0, 12, 10'h2E7, 1'b1, 1'b0, 2'b10);
    for (int f = 0; f < 256; f++) begin
      send(4'b0010, dev_addr, 8'(f), '0);
      check(got_v && got_d == ref_d && got_c == crc_ref(ref_d, 12), "R3",
            int'(got_d), int'(ref_d));
    end

    // R11: stall, then handover in the same cycle
    rsp_ready = 1'b0;
    accel = 10'h0F0; len_cfg = 4'd10;
    @(negedge clk);
    req_op = 4'b0010; req_addr = dev_addr; req_fill = 8'h00;
    req_crc = crc_ref({8'h00, dev_addr, 4'b0010}, 16); req_valid = 1'b1;
    @(negedge clk);
    ref_d = exp_word(1'b0, 10, 10'h0F0, err_flag, selftest, attr);
    check(rsp_valid && rsp_data == ref_d, "R11 first", int'(rsp_data), int'(ref_d));
    accel = 10'h00F; req_fill = 8'h77;
    req_crc = crc_ref({8'h77, dev_addr, 4'b0010}, 16);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check(rsp_valid && rsp_data == ref_d && !req_ready, "R11 hold",
            int'(rsp_data), int'(ref_d));
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    ref_d = exp_word(1'b0, 10, 10'h00F, err_flag, selftest, attr);
    check(rsp_valid && rsp_data == ref_d && rsp_crc == crc_ref(ref_d, 10), "R11 handover",
          int'(rsp_data), int'(ref_d));
    @(negedge clk);
    check(!rsp_valid, "R10 after handover", int'(rsp_valid), 0);

    finish_run();
  end
endmodule